// File: doc/BRIEF.md
# Start-up Boot and Memory Initialization Sequencer

After the external active-low reset pin is released, this block runs a fixed start-up window on the master clock. In that window it copies a boot ROM image into the coefficient parameter RAM, one word per cycle. In the same cycles it clears the data memory, one location per cycle. From the moment the pin drops until the window ends, it keeps a busy flag high so the host stays off the register port. The control registers get their reset from a synchronized copy of the pin.

Once the window has ended, the block gates the processing core's clock enable with the soft power-down request. A power-down stops the core but resets nothing and never starts the window again. Only the external pin can start a new boot.

The sequencer is a four-state machine:
- `ST_HOLD`: the synchronized reset is low.
- `ST_FILL`: the counted window, during which the copy and clear run.
- `ST_ACTIVE`: the core clock is enabled.
- `ST_SLEEP`: soft power-down.

Its transitions are:
- HOLD→FILL on the first edge after the synchronized reset releases.
- FILL→ACTIVE, or FILL→SLEEP if power-down is requested, on the last count of the window.
- ACTIVE→SLEEP when the request rises.
- SLEEP→ACTIVE when the request falls.
- Any state→HOLD asynchronously while the pin is low.

Top module: `boot_init_seq`

## Requirements
- R1: While the reset pin is low, and until the synchronized reset releases, `busy`=1, `core_ce`=0, `ctrl_rst_n`=0, and neither write strobe is active.
- R2: `ctrl_rst_n` deasserts on exactly the SYNC_STAGES-th (2) rising clock edge after the pin rises. It asserts immediately, without waiting for a clock, when the pin falls.
- R3: `busy` falls on exactly rising edge SYNC_STAGES+1+WINDOW (1027) after the pin rises. `core_ce` is never 1 while `busy` is 1.
- R4: During the window, each parameter RAM address from PRAM_LO (1) to PRAM_HI (254) is written exactly once. The data written is the ROM word at the same address, and `rom_addr` equals `pram_addr` on every write.
- R5: Parameter RAM addresses outside 1..254 (0 and 255) are never written. This holds even though the 10-bit counter passes through them.
- R6: During the window, each data RAM address 0..DRAM_DEPTH-1 (0..511) receives exactly one clear strobe on `dram_we` (meaning: write zero).
- R7: Outside the window, `core_ce` equals the inverse of `pdn_req` as sampled one rising edge earlier. In that period `busy` stays 0 and no write strobe occurs.
- R8: `pdn_req` has no effect on the window length. At the end of the window `core_ce` is the inverse of `pdn_req`.
- R9: A low pulse on the reset pin restarts the complete sequence, with full window length and a full copy and clear. This holds even for a pulse shorter than one clock period and whether it comes during the window or during sleep. Nothing else restarts the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_in_n | input | 1 | External reset pin, active low, asynchronous |
| pdn_req | input | 1 | Soft power-down request bit from the control register |
| rom_addr | output | 8 | Boot ROM read address |
| rom_data | input | 22 | Boot ROM read data (combinational read) |
| pram_we | output | 1 | Parameter RAM write enable |
| pram_addr | output | 8 | Parameter RAM write address |
| pram_wdata | output | 22 | Parameter RAM write data |
| dram_we | output | 1 | Data RAM clear strobe (write zero) |
| dram_addr | output | 9 | Data RAM clear address |
| ctrl_rst_n | output | 1 | Synchronized reset for the control registers |
| busy | output | 1 | Host access lockout, high from reset until the window ends |
| core_ce | output | 1 | Processing core clock enable |

## Verification
The main sequence is run under three kinds of reset release:
- A clean release from a long reset, which pins down the exact edge count and the complete one-per-address copy and clear.
- A sub-cycle pulse landing at a random point inside a running window, which separates a true restart from a counter that merely carries on.
- A pulse during soft power-down, which shows that a power-down state still yields to the pin.

The ROM image is random for each run. A stuck, shifted or misaligned data path therefore shows up as a word mismatch rather than matching a constant by chance.

Random power-down toggling in the running state, with random hold lengths, checks the one-edge response of the clock enable. It also shows that the request triggers no writes and no new window. Holding the request high through a whole window confirms that the request changes neither the window length nor the final state.

// File: rtl/bootseq_pkg.sv
package bootseq_pkg;

    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,
        ST_FILL   = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_SLEEP  = 2'd3
    } seq_state_t;

endpackage

// File: rtl/bootseq_sync.sv
module bootseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);

    logic [STAGES-1:0] chain;

    // asynchronous assert, synchronous release
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], 1'b1};
        end
    end

    assign srst_n = chain[STAGES-1];

endmodule

// File: rtl/bootseq_fsm.sv
module bootseq_fsm
    import bootseq_pkg::*;
#(
    parameter int WINDOW = 1024,
    parameter int CNT_W  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pdn_req,
    output seq_state_t       state,
    output logic [CNT_W-1:0] fill_cnt
);

    seq_state_t nxt;
    logic       last_slot;

    assign last_slot = (fill_cnt == CNT_W'(WINDOW - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HOLD;
        end else begin
            state <= nxt;
        end
    end

    // window counter: runs only inside the fill state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_cnt <= '0;
        end else if (state == ST_FILL) begin
            fill_cnt <= fill_cnt + 1'b1;
        end else begin
            fill_cnt <= '0;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_HOLD:   nxt = ST_FILL;
            ST_FILL:   if (last_slot) nxt = pdn_req ? ST_SLEEP : ST_ACTIVE;
            ST_ACTIVE: if (pdn_req)   nxt = ST_SLEEP;
            ST_SLEEP:  if (!pdn_req)  nxt = ST_ACTIVE;
            default:   nxt = ST_HOLD;
        endcase
    end

endmodule

// File: rtl/bootseq_wr_map.sv
module bootseq_wr_map #(
    parameter int CNT_W      = 10,
    parameter int PRAM_AW    = 8,
    parameter int PRAM_LO    = 1,
    parameter int PRAM_HI    = 254,
    parameter int DRAM_DEPTH = 512,
    parameter int DRAM_AW    = 9,
    parameter int WINDOW     = 1024
) (
    input  logic               fill_on,
    input  logic [CNT_W-1:0]   cnt,
    output logic [PRAM_AW-1:0] rom_addr,
    output logic               pram_we,
    output logic [PRAM_AW-1:0] pram_addr,
    output logic               dram_we,
    output logic [DRAM_AW-1:0] dram_addr
);

    logic [CNT_W:0] cnt_x;
    logic           in_pram;
    logic           in_dram;

    assign cnt_x   = {1'b0, cnt};
    assign in_pram = (cnt_x >= (CNT_W+1)'(PRAM_LO)) && (cnt_x <= (CNT_W+1)'(PRAM_HI));

    generate
        if (DRAM_DEPTH >= WINDOW) begin : g_dram_full
            assign in_dram = 1'b1;
        end else begin : g_dram_part
            assign in_dram = (cnt_x < (CNT_W+1)'(DRAM_DEPTH));
        end
    endgenerate

    assign rom_addr  = cnt[PRAM_AW-1:0];
    assign pram_addr = cnt[PRAM_AW-1:0];
    assign pram_we   = fill_on && in_pram;
    assign dram_addr = cnt[DRAM_AW-1:0];
    assign dram_we   = fill_on && in_dram;

endmodule

// File: rtl/boot_init_seq.sv
module boot_init_seq
    import bootseq_pkg::*;
#(
    parameter int WINDOW      = 1024,
    parameter int SYNC_STAGES = 2,
    parameter int PRAM_AW     = 8,
    parameter int PRAM_LO     = 1,
    parameter int PRAM_HI     = 254,
    parameter int COEF_W      = 22,
    parameter int DRAM_DEPTH  = 512
) (
    input  logic                                clk,
    input  logic                                rst_in_n,
    input  logic                                pdn_req,
    output logic [PRAM_AW-1:0]                  rom_addr,
    input  logic [COEF_W-1:0]                   rom_data,
    output logic                                pram_we,
    output logic [PRAM_AW-1:0]                  pram_addr,
    output logic [COEF_W-1:0]                   pram_wdata,
    output logic                                dram_we,
    output logic [$clog2(DRAM_DEPTH)-1:0]       dram_addr,
    output logic                                ctrl_rst_n,
    output logic                                busy,
    output logic                                core_ce
);

    localparam int CNT_W   = $clog2(WINDOW);
    localparam int DRAM_AW = $clog2(DRAM_DEPTH);

    seq_state_t       state;
    logic [CNT_W-1:0] fill_cnt;
    logic             srst_n;
    logic             fill_on;

    bootseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .arst_n (rst_in_n),
        .srst_n (srst_n)
    );

    bootseq_fsm #(.WINDOW(WINDOW), .CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (srst_n),
        .pdn_req  (pdn_req),
        .state    (state),
        .fill_cnt (fill_cnt)
    );

    bootseq_wr_map #(
        .CNT_W      (CNT_W),
        .PRAM_AW    (PRAM_AW),
        .PRAM_LO    (PRAM_LO),
        .PRAM_HI    (PRAM_HI),
        .DRAM_DEPTH (DRAM_DEPTH),
        .DRAM_AW    (DRAM_AW),
        .WINDOW     (WINDOW)
    ) u_map (
        .fill_on   (fill_on),
        .cnt       (fill_cnt),
        .rom_addr  (rom_addr),
        .pram_we   (pram_we),
        .pram_addr (pram_addr),
        .dram_we   (dram_we),
        .dram_addr (dram_addr)
    );

    // output decode
    always_comb begin
        busy    = 1'b1;
        core_ce = 1'b0;
        fill_on = 1'b0;
        unique case (state)
            ST_HOLD:   ;
            ST_FILL:   fill_on = 1'b1;
            ST_ACTIVE: begin
                busy    = 1'b0;
                core_ce = 1'b1;
            end
            ST_SLEEP:  busy = 1'b0;
            default:   ;
        endcase
    end

    assign pram_wdata = pram_we ? rom_data : '0;
    assign ctrl_rst_n = srst_n;

endmodule

// File: rtl/bootseq_chk.sv
module bootseq_chk #(
    parameter int WINDOW  = 1024,
    parameter int PRAM_AW = 8,
    parameter int PRAM_LO = 1,
    parameter int PRAM_HI = 254
) (
    input logic               clk,
    input logic               rst_in_n,
    input logic               pdn_req,
    input logic               pram_we,
    input logic [PRAM_AW-1:0] pram_addr,
    input logic               dram_we,
    input logic               ctrl_rst_n,
    input logic               busy,
    input logic               core_ce
);

    localparam int CW = $clog2(WINDOW + 2) + 1;

    logic [CW-1:0] win_cnt;

    // cycles with released sync reset and busy still high
    always_ff @(posedge clk or negedge rst_in_n) begin
        if (!rst_in_n) begin
            win_cnt <= '0;
        end else if (ctrl_rst_n && busy) begin
            win_cnt <= win_cnt + 1'b1;
        end
    end

    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_in_n)
        !ctrl_rst_n |-> (busy && !core_ce && !pram_we && !dram_we));

    assert_window_len_R3: assert property (@(posedge clk) disable iff (!rst_in_n)
        $fell(busy) |-> (win_cnt == CW'(WINDOW + 1)));

    assert_busy_gates_ce_R3: assert property (@(posedge clk) disable iff (!rst_in_n)
        busy |-> !core_ce);

    assert_pram_range_R5: assert property (@(posedge clk) disable iff (!rst_in_n)
        pram_we |-> ((pram_addr >= PRAM_AW'(PRAM_LO)) && (pram_addr <= PRAM_AW'(PRAM_HI))));

    assert_no_late_write_R7: assert property (@(posedge clk) disable iff (!rst_in_n)
        (pram_we || dram_we) |-> busy);

    assert_pdn_stops_R7: assert property (@(posedge clk) disable iff (!rst_in_n)
        (!busy && pdn_req) |=> !core_ce);

    assert_pdn_resumes_R7: assert property (@(posedge clk) disable iff (!rst_in_n)
        (!busy && !pdn_req) |=> (core_ce || busy));

endmodule

bind boot_init_seq bootseq_chk #(
    .WINDOW  (WINDOW),
    .PRAM_AW (PRAM_AW),
    .PRAM_LO (PRAM_LO),
    .PRAM_HI (PRAM_HI)
) u_chk (
    .clk        (clk),
    .rst_in_n   (rst_in_n),
    .pdn_req    (pdn_req),
    .pram_we    (pram_we),
    .pram_addr  (pram_addr),
    .dram_we    (dram_we),
    .ctrl_rst_n (ctrl_rst_n),
    .busy       (busy),
    .core_ce    (core_ce)
);

// File: tb/sim_boot_init_seq.sv
`timescale 1ns/1ps
module sim_boot_init_seq;

    localparam int WIN  = 1024;
    localparam int SYNC = 2;
    localparam int DD   = 512;

    logic        clk = 1'b0;
    logic        rst_in_n;
    logic        pdn_req;
    logic [7:0]  rom_addr;
    logic [21:0] rom_data;
    logic        pram_we;
    logic [7:0]  pram_addr;
    logic [21:0] pram_wdata;
    logic        dram_we;
    logic [8:0]  dram_addr;
    logic        ctrl_rst_n;
    logic        busy;
    logic        core_ce;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] rom_key = 32'h0;

    int          pram_hits [256];
    logic [21:0] pram_seen [256];
    int          dram_hits [512];
    int          addr_mis  = 0;
    int          ce_bad    = 0;
    int          wr_total  = 0;
    bit          done      = 1'b0;

    always #10 clk = ~clk;

    function automatic logic [21:0] rom_fn(input logic [7:0] a);
        logic [31:0] t;
        t = ({24'd0, a} * 32'd40503) ^ rom_key;
        return t[21:0] ^ {a, 14'h1b3};
    endfunction

    assign rom_data = rom_fn(rom_addr);

    boot_init_seq u0 (
        .clk        (clk),
        .rst_in_n   (rst_in_n),
        .pdn_req    (pdn_req),
        .rom_addr   (rom_addr),
        .rom_data   (rom_data),
        .pram_we    (pram_we),
        .pram_addr  (pram_addr),
        .pram_wdata (pram_wdata),
        .dram_we    (dram_we),
        .dram_addr  (dram_addr),
        .ctrl_rst_n (ctrl_rst_n),
        .busy       (busy),
        .core_ce    (core_ce)
    );

    always @(negedge clk) begin
        if (pram_we) begin
            pram_hits[pram_addr] = pram_hits[pram_addr] + 1;
            pram_seen[pram_addr] = pram_wdata;
            if (rom_addr != pram_addr) addr_mis = addr_mis + 1;
            wr_total = wr_total + 1;
        end
        if (dram_we) begin
            dram_hits[dram_addr] = dram_hits[dram_addr] + 1;
            wr_total = wr_total + 1;
        end
        if (busy && core_ce) ce_bad = ce_bad + 1;
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_models();
        for (int a = 0; a < 256; a++) begin
            pram_hits[a] = 0;
            pram_seen[a] = '1;
        end
        for (int a = 0; a < DD; a++) dram_hits[a] = 0;
        addr_mis = 0;
        ce_bad   = 0;
    endtask

    task automatic check_memories();
        int bad_in;
        int bad_out;
        int bad_d;
        bad_in = 0; bad_out = 0; bad_d = 0;
        for (int a = 0; a < 256; a++) begin
            if (a >= 1 && a <= 254) begin
                if (pram_hits[a] != 1 || pram_seen[a] !== rom_fn(8'(a))) bad_in++;
            end else if (pram_hits[a] != 0) begin
                bad_out++;
            end
        end
        for (int a = 0; a < DD; a++) if (dram_hits[a] != 1) bad_d++;
        chk("R4 parameter words copied once from ROM", bad_in, 0);
        chk("R4 rom_addr equals pram_addr", addr_mis, 0);
        chk("R5 addresses 0 and 255 untouched", bad_out, 0);
        chk("R6 data RAM cleared once per address", bad_d, 0);
        chk("R3 core_ce low while busy", ce_bad, 0);
    endtask

    // called just after the reset pin has risen, before the next rising edge
    task automatic measure(input bit pdn_exp, input string tag);
        int n;
        int rel;
        n = 0; rel = -1;
        while (n < 3000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (ctrl_rst_n && rel < 0) rel = n;
            if (!busy) break;
        end
        chk({"R2 ctrl_rst_n release edge ", tag}, rel, SYNC);
        chk({"R3 busy window edges ", tag}, n, SYNC + 1 + WIN);
        chk({"R8 core_ce at window end ", tag}, core_ce, !pdn_exp);
        check_memories();
    endtask

    // starts at a falling edge; pulse ends before the next rising edge when w < 9
    task automatic pulse_reset(input int w);
        #1 rst_in_n = 1'b0;
        #1;
        chk("R9 busy set by pulse", busy, 1);
        chk("R9 ctrl_rst_n asserted by pulse", ctrl_rst_n, 0);
        clear_models();
        #(w - 1) rst_in_n = 1'b1;
    endtask

    initial begin
        int w0;
        rst_in_n = 1'b0;
        pdn_req  = 1'b0;
        void'($urandom(32'd4242));
        rom_key = $urandom;
        clear_models();
        repeat (3) @(negedge clk);

        chk("R1 busy in reset", busy, 1);
        chk("R1 core_ce in reset", core_ce, 0);
        chk("R1 ctrl_rst_n in reset", ctrl_rst_n, 0);
        chk("R1 no pram write in reset", pram_we, 0);
        chk("R1 no dram write in reset", dram_we, 0);

        // clean release
        #3 rst_in_n = 1'b1;
        measure(1'b0, "first boot");

        // R7: random power-down toggling while running
        w0 = wr_total;
        for (int i = 0; i < 30; i++) begin
            bit p;
            int hold;
            p = 1'($urandom % 2);
            hold = 1 + int'($urandom % 4);
            pdn_req = p;
            for (int h = 0; h < hold; h++) begin
                @(posedge clk);
                @(negedge clk);
                chk("R7 core_ce follows pdn_req", core_ce, !p);
                chk("R7 busy stays low", busy, 0);
            end
        end
        chk("R7 no writes while running", wr_total - w0, 0);

        // R9 / R8: reset during sleep with pdn_req held high through the window
        pdn_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R7 asleep before pulse", core_ce, 0);
        pulse_reset(5);
        measure(1'b1, "after sleep pulse");
        pdn_req = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R8 wakes after window", core_ce, 1);

        // R9: short pulse at a random point inside a running window
        for (int k = 0; k < 3; k++) begin
            int d;
            bit p;
            p = 1'($urandom % 2);
            pdn_req = p;
            pulse_reset(15);
            d = 50 + int'($urandom % 950);
            repeat (d) @(negedge clk);
            chk("R9 still busy mid window", busy, 1);
            pulse_reset(5);
            measure(p, "after mid-window pulse");
            pdn_req = 1'b0;
            @(posedge clk);
            @(negedge clk);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule